// File: doc/BRIEF.md
# Write-Progress Status Read Path

This block forms the byte a byte-wide nonvolatile memory places on its data bus when it is read. In normal operation it passes the array word straight through. While the write engine reports that an internal programming cycle is running, it replaces the word with status that software can poll. The top bit carries the complement of the top bit of the byte most recently loaded, so it reads back wrong until programming ends. The next bit flips from one read to the next. The remaining bits echo the loaded byte.

Array storage, address latching and write timing belong to neighbouring blocks. This path decodes the read strobe from the three active-low controls and the reset. It decides whether the bus is driven and keeps the single bit of toggle state. A read is counted when its strobe is seen low at a clock edge after having been high.

Top module: `wip_status_rdpath`

## Requirements
- R1: `bus_oe` is 1 in the same cycle exactly when `rst_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1; otherwise it is 0.
- R2: Whenever `bus_oe` is 0, `bus_dout` is all zeros.
- R3: While `rst_n` is 0 the bus is not driven, and after reset the first read during a write shows bit 6 as 1.
- R4: With `wip`=0, a read drives `bus_dout` equal to `arr_rdata`.
- R5: With `wip`=1, a read drives bit 7 as the complement of bit 7 of `last_wbyte`.
- R6: With `wip`=1, a read drives bits 5 down to 0 equal to the same bits of `last_wbyte`.
- R7: The first read that sees `wip`=1 after a cycle with `wip`=0 shows bit 6 as 1.
- R8: Bit 6 holds steady for the whole of one read. Each read that ends while `wip` was 1 in its last cycle inverts bit 6 for the next read.
- R9: Once `wip` returns to 0, reads give true array data and the toggle is re-armed to 1.
- R10: A read ending at the same edge where `wip` rises, after that read saw `wip`=0, does not advance the toggle. A read ending at the edge where `wip` falls leaves the toggle re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also blocks the bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low (must be high to read) |
| wip | input | 1 | Internal write in progress, from the write controller |
| arr_rdata | input | 8 | Word read from the array |
| last_wbyte | input | 8 | Last byte loaded by the write controller |
| bus_dout | output | 8 | Data bus value |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
Two functions can land on the same clock edge: the toggle advance at the end of a read, and the re-arm or start of a write as `wip` changes. The stimulus ends a read in exactly the cycle `wip` falls, and later ends a true-data read in exactly the cycle `wip` rises. The following write-time read must show bit 6 as 1 in both cases. A wrong priority, or a read counted from the current `wip` rather than the one it saw, shows up as 0 there.

// File: rtl/wip_status_pkg.sv
package wip_status_pkg;

   typedef enum logic [1:0] {
      ROLE_PASS   = 2'd0,
      ROLE_POLL   = 2'd1,
      ROLE_TOGGLE = 2'd2
   } bit_role_e;

   function automatic bit_role_e role_of(input int idx, input int poll_bit, input int tgl_bit);
      if (idx == poll_bit)     return ROLE_POLL;
      else if (idx == tgl_bit) return ROLE_TOGGLE;
      else                     return ROLE_PASS;
   endfunction

endpackage

// File: rtl/wip_rd_strobe.sv
module wip_rd_strobe #(
   parameter bit CTRL_ACT_LOW = 1'b1
) (
   input  logic rst_n,
   input  logic ce_ctl,
   input  logic oe_ctl,
   input  logic we_ctl,
   output logic rd_act
);
   generate
      if (CTRL_ACT_LOW) begin : g_low
         assign rd_act = rst_n & ~ce_ctl & ~oe_ctl & we_ctl;
      end else begin : g_high
         assign rd_act = rst_n & ce_ctl & oe_ctl & ~we_ctl;
      end
   endgenerate
endmodule

// File: rtl/wip_toggle_track.sv
module wip_toggle_track #(
   parameter bit TGL_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_act,
   input  logic wip,
   output logic tgl
);
   logic rd_q;
   logic wip_q;
   logic rd_done;

   // a read has ended when its strobe was present last cycle and is gone now
   assign rd_done = rd_q & ~rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         wip_q <= 1'b0;
         tgl   <= TGL_INIT;
      end else begin
         rd_q  <= rd_act;
         wip_q <= wip;
         if (!wip) begin
            tgl <= TGL_INIT;
         end else if (rd_done && wip_q) begin
            tgl <= ~tgl;
         end
      end
   end
endmodule

// File: rtl/wip_bus_mux.sv
module wip_bus_mux
   import wip_status_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = DATA_W - 1,
   parameter int TGL_BIT  = DATA_W - 2
) (
   input  logic              rd_act,
   input  logic              wip,
   input  logic              tgl,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] last_wbyte,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] status_w;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam bit_role_e ROLE = role_of(i, POLL_BIT, TGL_BIT);
         if (ROLE == ROLE_POLL) begin : g_poll
            assign status_w[i] = ~last_wbyte[i];
         end else if (ROLE == ROLE_TOGGLE) begin : g_tgl
            assign status_w[i] = tgl;
         end else begin : g_pass
            assign status_w[i] = last_wbyte[i];
         end
      end
   endgenerate

   always_comb begin
      if (!rd_act)  dout = '0;
      else if (wip) dout = status_w;
      else          dout = arr_rdata;
   end
endmodule

// File: rtl/wip_status_rdpath.sv
module wip_status_rdpath #(
   parameter int DATA_W       = 8,
   parameter int POLL_BIT     = DATA_W - 1,
   parameter int TGL_BIT      = DATA_W - 2,
   parameter bit TGL_INIT     = 1'b1,
   parameter bit CTRL_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              wip,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] last_wbyte,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe
);
   localparam int MIN_W = 2;

   generate
      if (DATA_W < MIN_W) begin : g_bad_w
         initial $fatal(1, "DATA_W too small for two status bits");
      end
      if (POLL_BIT == TGL_BIT || POLL_BIT >= DATA_W || TGL_BIT >= DATA_W
          || POLL_BIT < 0 || TGL_BIT < 0) begin : g_bad_pos
         initial $fatal(1, "status bit positions invalid");
      end
   endgenerate

   logic rd_act;
   logic tgl;

   wip_rd_strobe #(.CTRL_ACT_LOW(CTRL_ACT_LOW)) u_strobe (
      .rst_n  (rst_n),
      .ce_ctl (ce_n),
      .oe_ctl (oe_n),
      .we_ctl (we_n),
      .rd_act (rd_act)
   );

   wip_toggle_track #(.TGL_INIT(TGL_INIT)) u_tgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_act (rd_act),
      .wip    (wip),
      .tgl    (tgl)
   );

   wip_bus_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) u_mux (
      .rd_act     (rd_act),
      .wip        (wip),
      .tgl        (tgl),
      .arr_rdata  (arr_rdata),
      .last_wbyte (last_wbyte),
      .dout       (bus_dout)
   );

   assign bus_oe = rd_act;
endmodule

// File: rtl/wip_status_rdpath_chk.sv
module wip_status_rdpath_chk #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = DATA_W - 1,
   parameter int TGL_BIT  = DATA_W - 2,
   parameter bit TGL_INIT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              wip,
   input logic [DATA_W-1:0] arr_rdata,
   input logic [DATA_W-1:0] last_wbyte,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_oe
);
   logic fresh_q;
   logic oe_q;
   logic last_b6;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q <= 1'b1;
         oe_q    <= 1'b0;
         last_b6 <= TGL_INIT;
      end else begin
         oe_q <= bus_oe;
         if (!wip)        fresh_q <= 1'b1;
         else if (bus_oe) fresh_q <= 1'b0;
         if (bus_oe && wip) last_b6 <= bus_dout[TGL_BIT];
      end
   end

   // R1
   oe_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!ce_n && !oe_n && we_n));
   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_dout == '0));
   // R4
   true_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !wip) |-> (bus_dout == arr_rdata));
   // R5
   poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && wip) |-> (bus_dout[POLL_BIT] == ~last_wbyte[POLL_BIT]));
   // R7
   first_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && wip && fresh_q) |-> (bus_dout[TGL_BIT] == TGL_INIT));
   // R8
   tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !oe_q && wip && !fresh_q) |-> (bus_dout[TGL_BIT] != last_b6));
   // R8
   tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && oe_q && wip && $past(wip)) |-> $stable(bus_dout[TGL_BIT]));
endmodule

bind wip_status_rdpath wip_status_rdpath_chk #(
   .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT), .TGL_INIT(TGL_INIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wip(wip),
   .arr_rdata(arr_rdata), .last_wbyte(last_wbyte), .bus_dout(bus_dout), .bus_oe(bus_oe)
);

// File: tb/wip_status_rdpath_tb.sv
module wip_status_rdpath_tb;
   localparam int CLK_NS = 4;
   localparam int NV     = 17;

   typedef struct packed {
      logic       ce_n;
      logic       oe_n;
      logic       we_n;
      logic       wip;
      logic [7:0] arr;
      logic [7:0] last;
      logic       e_oe;
      logic [7:0] e_do;
   } vec_t;

   // one entry per clock cycle; toggle state carries from row to row
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,1'b1,1'b0,8'hA5,8'h00,1'b0,8'h00}, // 0  idle           R1 R2
      '{1'b0,1'b0,1'b1,1'b0,8'hA5,8'h00,1'b1,8'hA5}, // 1  plain read     R4
      '{1'b0,1'b0,1'b0,1'b0,8'hA5,8'h00,1'b0,8'h00}, // 2  we low         R1
      '{1'b1,1'b1,1'b1,1'b1,8'hA5,8'h3C,1'b0,8'h00}, // 3  write starts
      '{1'b0,1'b0,1'b1,1'b1,8'hA5,8'h3C,1'b1,8'hFC}, // 4  first poll     R5 R6 R7
      '{1'b1,1'b1,1'b1,1'b1,8'hA5,8'h3C,1'b0,8'h00}, // 5  idle, flips
      '{1'b0,1'b0,1'b1,1'b1,8'hA5,8'h3C,1'b1,8'hBC}, // 6  second poll    R8
      '{1'b0,1'b0,1'b1,1'b1,8'hA5,8'h3C,1'b1,8'hBC}, // 7  same read      R8
      '{1'b1,1'b1,1'b1,1'b1,8'hA5,8'h81,1'b0,8'h00}, // 8  idle, flips
      '{1'b0,1'b0,1'b1,1'b1,8'hA5,8'h81,1'b1,8'h41}, // 9  third poll     R5 R8
      '{1'b1,1'b0,1'b1,1'b1,8'hA5,8'h81,1'b0,8'h00}, // 10 ce high, flips R1
      '{1'b0,1'b0,1'b1,1'b1,8'hA5,8'h81,1'b1,8'h01}, // 11 fourth poll    R8
      '{1'b1,1'b1,1'b1,1'b0,8'h5A,8'h81,1'b0,8'h00}, // 12 read end + done R10
      '{1'b0,1'b0,1'b1,1'b0,8'h5A,8'h81,1'b1,8'h5A}, // 13 true data     R9
      '{1'b1,1'b1,1'b1,1'b1,8'h5A,8'h00,1'b0,8'h00}, // 14 read end + start R10
      '{1'b0,1'b0,1'b1,1'b1,8'h5A,8'h00,1'b1,8'hC0}, // 15 rearmed        R9 R10
      '{1'b1,1'b1,1'b1,1'b1,8'h5A,8'h00,1'b0,8'h00}  // 16 idle
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wip = 1'b0;
   logic [7:0] arr_rdata = 8'h00, last_wbyte = 8'h00;
   logic [7:0] bus_dout;
   logic       bus_oe;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   wip_status_rdpath u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wip(wip),
      .arr_rdata(arr_rdata), .last_wbyte(last_wbyte), .bus_dout(bus_dout), .bus_oe(bus_oe)
   );

   function automatic string tag_of(input int i);
      case (i)
         0, 2, 10: return "R1";
         1:        return "R4";
         4:        return "R7";
         6, 7, 9, 11: return "R8";
         12, 14:   return "R10";
         13, 15:   return "R9";
         default:  return "R2";
      endcase
   endfunction

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {oe,dout} actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic c, input logic o, input logic w, input logic p,
                        input logic [7:0] a, input logic [7:0] l);
      ce_n = c; oe_n = o; we_n = w; wip = p; arr_rdata = a; last_wbyte = l;
   endtask

   initial begin
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 8'h00);
      #1 chk("R3", {bus_oe, bus_dout}, 9'h000);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i].ce_n, VECS[i].oe_n, VECS[i].we_n, VECS[i].wip,
               VECS[i].arr, VECS[i].last);
         #1 chk(tag_of(i), {bus_oe, bus_dout}, {VECS[i].e_oe, VECS[i].e_do});
      end
      // toggle now 0 with wip held; reset with read asserted: bus quiet (R3)
      @(negedge clk);
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h00);
      #1 chk("R3", {bus_oe, bus_dout}, 9'h000);
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h2A);
      #1 chk("R3", {bus_oe, bus_dout}, {1'b1, 8'hEA});
      // R6: low bits echo loaded byte, alternate pattern
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'hD5);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'hD5);
      #1 chk("R6", {bus_oe, bus_dout}, {1'b1, 8'h15});
      // R1: oe high alone blocks the bus during a write
      @(negedge clk);
      drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'hD5);
      #1 chk("R1", {bus_oe, bus_dout}, 9'h000);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule